// File: doc/BRIEF.md
# Scan-Wrapped Three-State Sequential Core

This block is a small synchronous machine with four functional inputs, three functional outputs and three state bits. Every state bit sits in a multiplexed-input scan cell, and the three cells form one serial chain. A single added test pin, `scan_en`, chooses between two behaviours. In normal capture mode each cell loads its next-state value. In shift mode the chain moves one place per clock from `scan_in` toward `scan_out`.

A tester uses the chain to test the combinational logic on its own. It shifts a chosen present state in over three clocks, most significant bit first. It then holds the functional inputs for one capture clock and reads the functional outputs just before that edge. Finally it shifts the captured next state out. Unloading overlaps with loading the next present state, so one vector costs three shift clocks plus one capture clock. A final three-clock unload follows the last vector.

The scan interface is a plain serial port. It has no handshake and no back-pressure, and it takes one bit on every clock while `scan_en` is high.

Top module: `scanwrap_core`

## Requirements
- R1: While `rst_n` is low, all three state bits are 0, so `scan_out` reads 0. Reset is asynchronous and active low.
- R2: `scan_out` always shows the last chain cell, state bit 2. Before the first shift clock of an unload it presents state bit 2, then bit 1, then bit 0.
- R3: With `scan_en` high, each rising edge moves the state as follows: bit 0 takes `scan_in`, bit 1 takes the old bit 0, and bit 2 takes the old bit 1. Feeding p[2], p[1], p[0] over three clocks therefore loads present state p.
- R4: While `scan_en` is high, `func_in` has no effect on the state. The bits shifted out equal the bits captured, whatever `func_in` does during the shift.
- R5: With `scan_en` low, each rising edge loads next state n from present state s and inputs i, as follows: n[0] = i[0] ^ (s[1] & i[3]), n[1] = i[1] ^ (s[2] & i[3]), n[2] = i[2] ^ (s[0] & i[3]).
- R6: `func_out` is combinational from the present state and inputs, as follows: o[0] = s[0] ^ i[1], o[1] = s[1] ^ i[2], o[2] = s[2] ^ i[3].
- R7: The captured next state of one vector shifts out unchanged during the three shift clocks that load the next vector. A vector therefore costs 3 + 1 clocks.
- R8: Several capture clocks in a row make the machine run in functional mode. Each edge applies R5 to the state left by the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | 1 = shift the chain, 0 = functional capture |
| scan_in | input | 1 | Serial data into chain cell 0 |
| func_in | input | 4 | Functional inputs |
| func_out | output | 3 | Functional outputs |
| scan_out | output | 1 | Serial data from the last chain cell |

## Verification
The assertions assume that `scan_en`, `scan_in` and `func_in` hold known, settled values at every rising edge. They also assume that reset is applied before the first checked edge. The stimulus meets these conditions by changing every input 1 ns after a rising edge and starting with a reset pulse. During reset it keeps `scan_en` high with `scan_in` at 0, so the cleared state survives until the first vector. During shifts the stimulus scrambles `func_in`, which exercises the claim that inputs are ignored while shifting.

// File: rtl/scanwrap_pkg.sv
package scanwrap_pkg;
  localparam int unsigned DEF_N_IN    = 4;
  localparam int unsigned DEF_N_OUT   = 3;
  localparam int unsigned DEF_N_STATE = 3;

  typedef enum logic {
    MODE_CAPTURE = 1'b0,
    MODE_SHIFT   = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/scanwrap_cell.sv
module scanwrap_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_shift,
  input  logic d_func,
  input  logic d_scan,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sel_shift ? d_scan : d_func;
  end
endmodule

// File: rtl/scanwrap_logic.sv
module scanwrap_logic #(
  parameter int unsigned N_IN    = scanwrap_pkg::DEF_N_IN,
  parameter int unsigned N_OUT   = scanwrap_pkg::DEF_N_OUT,
  parameter int unsigned N_STATE = scanwrap_pkg::DEF_N_STATE
) (
  input  logic [N_IN-1:0]    fin,
  input  logic [N_STATE-1:0] ps,
  output logic [N_STATE-1:0] ns,
  output logic [N_OUT-1:0]   fout
);
  localparam int unsigned MIX_BIT = N_IN - 1;

  for (genvar g = 0; g < N_STATE; g++) begin : g_next
    assign ns[g] = fin[g % N_IN] ^ (ps[(g + 1) % N_STATE] & fin[MIX_BIT]);
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    assign fout[g] = ps[g % N_STATE] ^ fin[(g + 1) % N_IN];
  end
endmodule

// File: rtl/scanwrap_core.sv
module scanwrap_core #(
  parameter int unsigned N_IN    = scanwrap_pkg::DEF_N_IN,
  parameter int unsigned N_OUT   = scanwrap_pkg::DEF_N_OUT,
  parameter int unsigned N_STATE = scanwrap_pkg::DEF_N_STATE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             scan_in,
  input  logic [N_IN-1:0]  func_in,
  output logic [N_OUT-1:0] func_out,
  output logic             scan_out
);
  localparam int unsigned TAIL = N_STATE - 1;

  logic [N_STATE-1:0] state_q;
  logic [N_STATE-1:0] next_d;
  logic [N_STATE-1:0] chain_d;
  scanwrap_pkg::scan_mode_e mode;

  assign mode = scanwrap_pkg::scan_mode_e'(scan_en);

  scanwrap_logic #(.N_IN(N_IN), .N_OUT(N_OUT), .N_STATE(N_STATE)) u_logic (
    .fin  (func_in),
    .ps   (state_q),
    .ns   (next_d),
    .fout (func_out)
  );

  for (genvar k = 0; k < N_STATE; k++) begin : g_chain
    if (k == 0) begin : g_head
      assign chain_d[k] = scan_in;
    end else begin : g_link
      assign chain_d[k] = state_q[k-1];
    end
    scanwrap_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_shift (mode == scanwrap_pkg::MODE_SHIFT),
      .d_func    (next_d[k]),
      .d_scan    (chain_d[k]),
      .q         (state_q[k])
    );
  end

  assign scan_out = state_q[TAIL];
endmodule

// File: rtl/scanwrap_core_chk.sv
module scanwrap_core_chk #(
  parameter int unsigned N_IN    = 4,
  parameter int unsigned N_OUT   = 3,
  parameter int unsigned N_STATE = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_en,
  input logic             scan_in,
  input logic [N_IN-1:0]  func_in,
  input logic [N_OUT-1:0] func_out,
  input logic             scan_out,
  input logic [N_STATE-1:0] state
);
  function automatic logic [N_STATE-1:0] model_next(input logic [N_IN-1:0] i,
                                                    input logic [N_STATE-1:0] s);
    logic [N_STATE-1:0] r;
    for (int b = 0; b < N_STATE; b++) begin
      r[b] = i[b % N_IN];
      if (i[N_IN-1]) r[b] = r[b] ^ s[(b + 1) % N_STATE];
    end
    return r;
  endfunction

  function automatic logic [N_OUT-1:0] model_out(input logic [N_IN-1:0] i,
                                                 input logic [N_STATE-1:0] s);
    logic [N_OUT-1:0] r;
    for (int b = 0; b < N_OUT; b++) r[b] = (s[b % N_STATE] != i[(b + 1) % N_IN]);
    return r;
  endfunction

  // R1: reset holds the chain cleared
  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_clear: assert (state == '0 && scan_out == 1'b0);
  end

  // R2: serial output is the tail cell
  a_r2_tail_visible: assert property (@(posedge clk) disable iff (!rst_n)
    scan_out == state[N_STATE-1]);

  // R3 / R4: shift moves the chain regardless of functional inputs
  a_r3_shift_move: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> state == {$past(state[N_STATE-2:0]), $past(scan_in)});

  // R5 / R8: capture loads the next-state function
  a_r5_capture_next: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> state == model_next($past(func_in), $past(state)));

  // R6: outputs follow present state and inputs
  a_r6_output_func: assert property (@(posedge clk) disable iff (!rst_n)
    func_out == model_out(func_in, state));
endmodule

bind scanwrap_core scanwrap_core_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .N_STATE(N_STATE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scan_en  (scan_en),
  .scan_in  (scan_in),
  .func_in  (func_in),
  .func_out (func_out),
  .scan_out (scan_out),
  .state    (state_q)
);

// File: tb/test_scanwrap_core.sv
`timescale 1ns/1ps
module test_scanwrap_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       scan_en = 1'b1;
  logic       scan_in = 1'b0;
  logic [3:0] func_in = 4'b1010;
  logic [2:0] func_out;
  logic       scan_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic       bit_q[$];
  string      bit_tag[$];
  logic [2:0] out_q[$];
  string      out_tag[$];
  logic [2:0] cur_state = 3'b000;

  always #2.5 clk = ~clk;

  scanwrap_core i_scanwrap_core (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .func_in(func_in), .func_out(func_out), .scan_out(scan_out)
  );

  function automatic logic [2:0] ref_next(input logic [3:0] i, input logic [2:0] s);
    logic [2:0] n;
    n[0] = i[0] ^ (s[1] & i[3]);
    n[1] = i[1] ^ (s[2] & i[3]);
    n[2] = i[2] ^ (s[0] & i[3]);
    return n;
  endfunction

  function automatic logic [2:0] ref_out(input logic [3:0] i, input logic [2:0] s);
    return {s[2] ^ i[3], s[1] ^ i[2], s[0] ^ i[1]};
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Monitor: compares shifted-out bits and captured outputs
  always @(negedge clk) begin
    if (rst_n) begin
      if (scan_en && bit_q.size() > 0)
        check(bit_tag.pop_front(), {2'b00, scan_out}, {2'b00, bit_q.pop_front()});
      if (!scan_en && out_q.size() > 0)
        check(out_tag.pop_front(), func_out, out_q.pop_front());
    end
  end

  task automatic shift_bit(input logic b);
    @(posedge clk); #1;
    scan_en = 1'b1;
    scan_in = b;
    func_in = 4'($urandom);   // R4: inputs toggle while shifting
  endtask

  task automatic load_state(input logic [2:0] p);
    for (int k = 2; k >= 0; k--) shift_bit(p[k]);   // R3: MSB first
    cur_state = p;
  endtask

  task automatic capture(input logic [3:0] i, input string tag);
    logic [2:0] n;
    @(posedge clk); #1;
    scan_en = 1'b0;
    func_in = i;
    out_q.push_back(ref_out(i, cur_state));
    out_tag.push_back({"R6 ", tag});
    n = ref_next(i, cur_state);
    cur_state = n;
  endtask

  task automatic expect_unload(input string tag);
    for (int k = 2; k >= 0; k--) begin
      bit_q.push_back(cur_state[k]);
      bit_tag.push_back({"R5/R7/R2 ", tag});
    end
  endtask

  task automatic vector(input logic [2:0] p, input logic [3:0] i);
    load_state(p);
    capture(i, "vector");
    expect_unload("vector");
  endtask

  initial begin
    #1 rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset scan_out", {2'b00, scan_out}, 3'b000);
    check("R6 reset outputs", func_out, 3'b101);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R1: the reset state is unloaded during the first load
    for (int k = 0; k < 3; k++) begin
      bit_q.push_back(1'b0);
      bit_tag.push_back("R1 reset unload");
    end
    vector(3'b000, 4'b0000);
    vector(3'b111, 4'b1111);
    vector(3'b101, 4'b1000);
    vector(3'b010, 4'b0111);
    vector(3'b110, 4'b1011);
    vector(3'b001, 4'b1100);
    for (int v = 0; v < 16; v++) vector(3'($urandom), 4'($urandom));
    // R8: functional run of three captures in a row
    load_state(3'b011);
    capture(4'b1001, "R8 run1");
    capture(4'b1110, "R8 run2");
    capture(4'b1101, "R8 run3");
    expect_unload("R8 run");
    // final unload
    for (int k = 0; k < 3; k++) shift_bit(1'b0);
    @(posedge clk); #1;
    @(negedge clk);
    check("R7 queue drained", 3'(bit_q.size() + out_q.size()), 3'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("[TB] FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule